// File: doc/BRIEF.md
# Input Qualification Filter for a General-Purpose Pin Bank

This block cleans up a bank of asynchronous input pins before any other logic uses them. Each raw pin first crosses into the system clock domain through a two-flop synchronizer. At a programmable rate, the block then shifts the synchronized level into a short per-pin history. A pin's filtered output moves to a new level only when a whole window of recent samples agrees on that level. Shorter pulses are discarded, and the output keeps its last qualified value.

The pins are arranged in groups of eight. Each group has its own 8-bit spacing field in one 32-bit control word. A field value of zero takes a sample on every clock. A nonzero value N spaces samples 2×N clocks apart. Each pin has a select input that chooses a window of three or six samples. The control word is written through a simple write port with one strobe per field and is always visible on a read-data output.

Top module: `gpio_qual_filter`

## Requirements
- R1: While reset is asserted and right after it is released, every filtered output and every spacing field reads zero.
- R2: The spacing field of group g occupies control bits 8g+7..8g and applies to pins 8g..8g+7. A write with field strobe g high loads that field. A write with strobe g low leaves that field unchanged. The read-data output always shows the stored fields.
- R3: With a spacing field of zero, a sample is taken on every clock. A 0-to-1 step held on a pin with a three-sample window appears on its output at the fifth rising edge after the step is presented, and not before.
- R4: With a spacing field N greater than zero, consecutive samples of that group are exactly 2×N clocks apart. For example, N=0xFF gives 510 clocks. Between samples, the group's outputs do not change.
- R5: Writing a group's field restarts that group's spacing count. With the new value N, the first sample after the write is taken at the 2×N-th rising edge after the write edge. With a new value of zero, a sample is taken at every edge.
- R6: Window select bit 1 selects six samples and bit 0 selects three samples. An output takes a new level only at a sample where all samples in its window equal that level.
- R7: An input pulse shorter than the window leaves the output at its previous value.
- R8: The groups run independently. Each group's sample timing depends only on its own field and its own writes.
- R9: A change of a pin's window select takes effect at that pin's next sample and keeps the samples already in its history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Raw asynchronous pin levels |
| ctrl_we_i | input | 1 | Control write enable |
| ctrl_be_i | input | 4 | Per-field write strobes, bit g for group g |
| ctrl_wdata_i | input | 32 | Control write data |
| ctrl_rdata_o | output | 32 | Current control word |
| win_long_i | input | 32 | Per-pin window select: 1 = six samples, 0 = three samples |
| qual_o | output | 32 | Qualified pin levels |

## Verification
The checker enforces several rules on every cycle:
- Outputs stay stable between a group's sample strobes.
- A zero field strobes on every clock.
- A nonzero field never strobes twice in a row.
- A write restarts the count and loads exactly the strobed fields.
- Any output change matches the newest history sample.

Some behaviour only the bench scenarios can show: the exact five- and eight-edge latencies, the 510-clock spacing, glitch rejection, and window-select changes that keep the history. The bench shows these by comparing against an independent cycle model and by directed latency checks.

// File: rtl/gpio_qual_pkg.sv
package gpio_qual_pkg;
  localparam int unsigned HIST_LEN  = 6;
  localparam int unsigned SHORT_WIN = 3;
  localparam int unsigned SYNC_LEN  = 2;
endpackage

// File: rtl/gpio_qual_sync.sv
module gpio_qual_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/gpio_qual_timer.sv
module gpio_qual_timer #(
  parameter int unsigned PRD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  input  logic [PRD_W-1:0] prd_i,
  output logic             strobe_o
);
  localparam int unsigned CNT_W = PRD_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;

  // zero -> every clock, N -> 2N clocks
  assign term     = (prd_i == '0) ? '0 : ({prd_i, 1'b0} - CNT_W'(1));
  assign strobe_o = (cnt_q == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (reload_i) cnt_q <= '0;
    else if (strobe_o) cnt_q <= '0;
    else               cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/gpio_qual_pin.sv
module gpio_qual_pin #(
  parameter int unsigned HIST_LEN  = 6,
  parameter int unsigned SHORT_WIN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic level_i,
  input  logic win_long_i,
  output logic qual_o,
  output logic hist_lsb_o
);
  logic [HIST_LEN-1:0] hist_q;
  logic [HIST_LEN-1:0] hist_d;
  logic                agree;

  assign hist_d = {hist_q[HIST_LEN-2:0], level_i};

  always_comb begin
    if (win_long_i) agree = (&hist_d) | ~(|hist_d);
    else            agree = (&hist_d[SHORT_WIN-1:0]) | ~(|hist_d[SHORT_WIN-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      qual_o <= 1'b0;
    end else if (strobe_i) begin
      hist_q <= hist_d;
      if (agree) qual_o <= hist_d[0];
    end
  end

  assign hist_lsb_o = hist_q[0];
endmodule

// File: rtl/gpio_qual_filter.sv
module gpio_qual_filter
  import gpio_qual_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 32,
  parameter int unsigned GROUP_PINS = 8,
  parameter int unsigned PRD_W      = 8
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic [NUM_PINS-1:0]                      pin_i,
  input  logic                                     ctrl_we_i,
  input  logic [NUM_PINS/GROUP_PINS-1:0]           ctrl_be_i,
  input  logic [(NUM_PINS/GROUP_PINS)*PRD_W-1:0]   ctrl_wdata_i,
  output logic [(NUM_PINS/GROUP_PINS)*PRD_W-1:0]   ctrl_rdata_o,
  input  logic [NUM_PINS-1:0]                      win_long_i,
  output logic [NUM_PINS-1:0]                      qual_o
);
  localparam int unsigned NUM_GROUPS = NUM_PINS / GROUP_PINS;

  logic [NUM_GROUPS-1:0][PRD_W-1:0] prd_q;
  logic [NUM_GROUPS-1:0]            field_wr;
  logic [NUM_GROUPS-1:0]            grp_strobe;
  logic [NUM_PINS-1:0]              pin_sync;
  logic [NUM_PINS-1:0]              hist_lsb;

  gpio_qual_sync #(
    .WIDTH (NUM_PINS),
    .STAGES(SYNC_LEN)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign field_wr[g] = ctrl_we_i & ctrl_be_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          prd_q[g] <= '0;
      else if (field_wr[g]) prd_q[g] <= ctrl_wdata_i[g*PRD_W +: PRD_W];
    end

    gpio_qual_timer #(
      .PRD_W(PRD_W)
    ) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .reload_i(field_wr[g]),
      .prd_i   (prd_q[g]),
      .strobe_o(grp_strobe[g])
    );

    for (genvar p = 0; p < GROUP_PINS; p++) begin : g_pin
      localparam int unsigned IDX = g * GROUP_PINS + p;
      gpio_qual_pin #(
        .HIST_LEN (HIST_LEN),
        .SHORT_WIN(SHORT_WIN)
      ) u_pin (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .strobe_i  (grp_strobe[g]),
        .level_i   (pin_sync[IDX]),
        .win_long_i(win_long_i[IDX]),
        .qual_o    (qual_o[IDX]),
        .hist_lsb_o(hist_lsb[IDX])
      );
    end
  end

  assign ctrl_rdata_o = prd_q;
endmodule

// File: rtl/gpio_qual_filter_chk.sv
module gpio_qual_filter_chk #(
  parameter int unsigned NUM_PINS   = 32,
  parameter int unsigned GROUP_PINS = 8,
  parameter int unsigned PRD_W      = 8
) (
  input logic                                   clk_i,
  input logic                                   rst_ni,
  input logic                                   ctrl_we_i,
  input logic [NUM_PINS/GROUP_PINS-1:0]         ctrl_be_i,
  input logic [(NUM_PINS/GROUP_PINS)*PRD_W-1:0] ctrl_wdata_i,
  input logic [(NUM_PINS/GROUP_PINS)*PRD_W-1:0] ctrl_rdata_o,
  input logic [NUM_PINS-1:0]                    qual_o,
  input logic [NUM_PINS/GROUP_PINS-1:0]         grp_strobe,
  input logic [NUM_PINS-1:0]                    hist_lsb
);
  localparam int unsigned NUM_GROUPS = NUM_PINS / GROUP_PINS;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r1: assert (qual_o == '0 && ctrl_rdata_o == '0)
        else $error("reset state not clear");
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    p_field_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_we_i && ctrl_be_i[g]) |=>
        ctrl_rdata_o[g*PRD_W +: PRD_W] == $past(ctrl_wdata_i[g*PRD_W +: PRD_W]));

    p_field_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(ctrl_we_i && ctrl_be_i[g]) |=> $stable(ctrl_rdata_o[g*PRD_W +: PRD_W]));

    p_zero_every_clk_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_rdata_o[g*PRD_W +: PRD_W] == '0) |-> grp_strobe[g]);

    p_hold_between_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !grp_strobe[g] |=> $stable(qual_o[g*GROUP_PINS +: GROUP_PINS]));

    p_no_back_to_back_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grp_strobe[g] && ctrl_rdata_o[g*PRD_W +: PRD_W] != '0 &&
       !(ctrl_we_i && ctrl_be_i[g])) |=> !grp_strobe[g]);

    p_write_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_we_i && ctrl_be_i[g] && ctrl_wdata_i[g*PRD_W +: PRD_W] != '0) |=> !grp_strobe[g]);
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    p_change_from_hist_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (qual_o[i] != $past(qual_o[i])) |-> (hist_lsb[i] == qual_o[i]));
  end
endmodule

bind gpio_qual_filter gpio_qual_filter_chk #(
  .NUM_PINS  (NUM_PINS),
  .GROUP_PINS(GROUP_PINS),
  .PRD_W     (PRD_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_we_i   (ctrl_we_i),
  .ctrl_be_i   (ctrl_be_i),
  .ctrl_wdata_i(ctrl_wdata_i),
  .ctrl_rdata_o(ctrl_rdata_o),
  .qual_o      (qual_o),
  .grp_strobe  (grp_strobe),
  .hist_lsb    (hist_lsb)
);

// File: tb/gpio_qual_filter_test.sv
`timescale 1ns/1ps
module gpio_qual_filter_test;
  localparam int NP = 32;
  localparam int NG = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pin;
  logic          we;
  logic [NG-1:0] be;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic [NP-1:0] win6;
  logic [NP-1:0] qual;

  int errors = 0;
  int checks = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  gpio_qual_filter uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pin_i       (pin),
    .ctrl_we_i   (we),
    .ctrl_be_i   (be),
    .ctrl_wdata_i(wdata),
    .ctrl_rdata_o(rdata),
    .win_long_i  (win6),
    .qual_o      (qual)
  );

  // reference model built from the requirements
  logic [NP-1:0] m_s1, m_s2, m_q;
  logic [5:0]    m_h [NP];
  logic [7:0]    m_prd [NG];
  int            m_since [NG];

  function automatic int spacing(input logic [7:0] f);
    return (f == 8'd0) ? 1 : 2 * int'(f);
  endfunction

  always @(posedge clk) begin
    logic st [NG];
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_q = '0;
      for (int i = 0; i < NP; i++) m_h[i] = '0;
      for (int g = 0; g < NG; g++) begin m_prd[g] = '0; m_since[g] = 0; end
    end else begin
      for (int g = 0; g < NG; g++) st[g] = (m_since[g] + 1 == spacing(m_prd[g]));
      for (int i = 0; i < NP; i++) begin
        if (st[i/8]) begin
          m_h[i] = {m_h[i][4:0], m_s2[i]};
          if (win6[i]) begin
            if (m_h[i] == 6'h3f) m_q[i] = 1'b1;
            else if (m_h[i] == 6'h00) m_q[i] = 1'b0;
          end else begin
            if (m_h[i][2:0] == 3'b111) m_q[i] = 1'b1;
            else if (m_h[i][2:0] == 3'b000) m_q[i] = 1'b0;
          end
        end
      end
      m_s2 = m_s1;
      m_s1 = pin;
      for (int g = 0; g < NG; g++) begin
        if (we && be[g]) begin
          m_prd[g] = wdata[g*8 +: 8];
          m_since[g] = 0;
        end else if (st[g]) m_since[g] = 0;
        else m_since[g] = m_since[g] + 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // every cycle: outputs and control word against the model
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      check(tag, qual, m_q);
      check(tag, rdata, {m_prd[3], m_prd[2], m_prd[1], m_prd[0]});
    end
  end

  task automatic wr(input logic [NG-1:0] strobes, input logic [31:0] d);
    we = 1'b1; be = strobes; wdata = d;
    @(negedge clk);
    we = 1'b0; be = '0;
  endtask

  initial begin
    rst_n = 1'b0; pin = '0; we = 1'b0; be = '0; wdata = '0; win6 = '0;
    repeat (3) @(negedge clk);
    check("R1", qual, 32'h0);
    check("R1", rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", qual, 32'h0);

    // R3 / R6 latency at zero spacing
    tag = "R3";
    win6 = 32'h2;
    pin  = 32'h3;
    repeat (4) @(negedge clk);
    check("R3", {31'd0, qual[0]}, 32'd0);
    @(negedge clk);
    check("R3", {31'd0, qual[0]}, 32'd1);
    check("R6", {31'd0, qual[1]}, 32'd0);
    repeat (2) @(negedge clk);
    check("R6", {31'd0, qual[1]}, 32'd0);
    @(negedge clk);
    check("R6", {31'd0, qual[1]}, 32'd1);

    // R7 short glitches
    tag = "R7";
    pin[0] = 1'b0; pin[1] = 1'b0;
    repeat (2) @(negedge clk);
    pin[0] = 1'b1;
    repeat (3) @(negedge clk);
    pin[1] = 1'b1;
    repeat (10) @(negedge clk);
    check("R7", {30'd0, qual[1:0]}, 32'd3);

    // R9 window change keeps history
    tag = "R9";
    pin[2] = 1'b1;
    repeat (3) @(negedge clk);
    win6[2] = 1'b1;
    repeat (2) @(negedge clk);
    check("R9", {31'd0, qual[2]}, 32'd0);
    repeat (3) @(negedge clk);
    check("R9", {31'd0, qual[2]}, 32'd1);

    // R4 widest spacing on group 3 only
    tag = "R4";
    pin[24] = 1'b1;
    wr(4'b1000, 32'hFF00_0000);
    check("R2", rdata, 32'hFF00_0000);
    repeat (1529) @(negedge clk);
    check("R4", {31'd0, qual[24]}, 32'd0);
    @(negedge clk);
    check("R4", {31'd0, qual[24]}, 32'd1);

    // R2 strobe selectivity
    tag = "R2";
    wr(4'b0101, 32'hAA03_5501);
    check("R2", rdata, 32'hFF03_0001);

    // R5 / R8 random mix with small spacings
    void'($urandom(32'd1234));
    for (int k = 0; k < 6000; k++) begin
      tag = (k < 3000) ? "R8" : "R5";
      if ($urandom_range(0, 9) == 0) pin ^= (32'h1 << $urandom_range(0, 31));
      if ($urandom_range(0, 49) == 0) win6 ^= (32'h1 << $urandom_range(0, 31));
      if ($urandom_range(0, 199) == 0) begin
        we = 1'b1;
        be = 4'($urandom_range(1, 15));
        wdata = {8'($urandom_range(0, 3)), 8'($urandom_range(0, 3)),
                 8'($urandom_range(0, 3)), 8'($urandom_range(0, 3))};
      end else begin
        we = 1'b0; be = '0;
      end
      @(negedge clk);
    end
    we = 1'b0;
    repeat (50) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule